// File: doc/BRIEF.md
# Byte-Sliced Pipelined Adder

This block adds two 32-bit operands and a carry-in, cutting the carry chain at every byte boundary. Four 8-bit adder slices each sit in their own pipeline stage. Each slice adds its byte of the operands to the carry that the slice below registered one cycle earlier, so the carry climbs one stage per clock. A new problem can enter every clock, and up to four problems are in flight at once, each occupying a different slice.

Because byte k is added k cycles after the problem arrives, the operand bytes for the upper slices are held back on the way in. The sum bytes of the lower slices are held back on the way out, so that all four sum bytes and the final carry leave together as one word. A valid flag travels with each problem, and the result appears exactly four clocks after its operands. There is no stall or backpressure: the pipeline advances on every clock.

The block has no control state machine. Every stage advances unconditionally, and the only sequencing is the fixed entry and exit skew described above.

Top module: `byte_pipe_adder`

## Requirements
- R1: While reset (active-low `rst_n`) is held, `out_valid`, `out_sum` and `out_cout` are all 0.
- R2: For a problem presented with `in_valid` = 1, `out_sum` equals (`in_a` + `in_b` + `in_cin`) mod 2^32 four clocks later.
- R3: In the same cycle, `out_cout` equals bit 32 of `in_a` + `in_b` + `in_cin`.
- R4: `out_valid` is 1 exactly four clocks after a cycle with `in_valid` = 1, and 0 four clocks after a cycle with `in_valid` = 0. In particular, it stays 0 during the three clocks before a result is due.
- R5: Problems presented on consecutive clocks produce their results on consecutive clocks, in the same order, with no gaps.
- R6: A carry that ripples through all four byte slices is handled. For example, 0xFFFFFFFF + 0x00000000 + 1 gives a sum of 0x00000000 and a carry-out of 1.
- R7: A carry generated at a byte boundary reaches the slice above in the correct stage. For example, 0x000000FF + 0x00000001 gives 0x00000100, and 0x00FFFFFF + 1 gives 0x01000000.
- R8: Cycles with `in_valid` = 0 that are interleaved with valid problems do not corrupt the results of those valid problems, whatever operand data is present during the idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every stage advances on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the operands in this cycle as a problem |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_cin | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | Marks a completed result |
| out_sum | output | 32 | Aligned 32-bit sum |
| out_cout | output | 1 | Carry out of bit 31 |

## Verification
The bench builds the adder with its default parameters: slices 8 bits wide and four slices deep. This setting puts every carry crossing (bit 7 into 8, 15 into 16, 23 into 24, and out of 31) into its own stage, so a mis-timed skew or deskew register shows up as a wrong byte. Back-to-back streams fill all four slices with different problems at once. Patterns with gaps expose a valid flag that is misaligned with its data.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
    localparam int unsigned DEF_SLICE_W = 8;
    localparam int unsigned DEF_SLICES  = 4;

    // Total number of register stages a problem crosses from input to output.
    function automatic int unsigned pipe_latency(input int unsigned slices);
        return slices;
    endfunction
endpackage

// File: rtl/bpa_delay.sv
module bpa_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] stage_q [DEPTH];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= d;
                    for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
                end
            end
            assign q = stage_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/bpa_slice.sv
module bpa_slice #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum_q,
    output logic         cout_q
);
    logic [W:0] total;

    always_comb begin
        total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q  <= '0;
            cout_q <= 1'b0;
        end else begin
            sum_q  <= total[W-1:0];
            cout_q <= total[W];
        end
    end
endmodule

// File: rtl/byte_pipe_adder.sv
module byte_pipe_adder
    import bpa_pkg::*;
#(
    parameter  int SLICE_W = DEF_SLICE_W,
    parameter  int SLICES  = DEF_SLICES,
    localparam int WIDTH   = SLICE_W * SLICES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             in_cin,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_sum,
    output logic             out_cout
);
    localparam int LAT = pipe_latency(SLICES);

    logic [SLICES-1:0]              carry_q;
    logic [SLICES-1:0][SLICE_W-1:0] sum_raw;
    logic [SLICES-1:0][SLICE_W-1:0] sum_aligned;

    generate
        for (genvar k = 0; k < SLICES; k++) begin : g_slice
            logic [2*SLICE_W-1:0] opnd;
            logic                 cin_k;

            // Entry skew: byte k waits k clocks for the carry from below.
            bpa_delay #(.W(2*SLICE_W), .DEPTH(k)) u_skew (
                .clk   (clk),
                .rst_n (rst_n),
                .d     ({in_a[k*SLICE_W +: SLICE_W], in_b[k*SLICE_W +: SLICE_W]}),
                .q     (opnd)
            );

            if (k == 0) begin : g_lsb
                assign cin_k = in_cin;
            end else begin : g_upper
                assign cin_k = carry_q[k-1];
            end

            bpa_slice #(.W(SLICE_W)) u_add (
                .clk    (clk),
                .rst_n  (rst_n),
                .a      (opnd[2*SLICE_W-1:SLICE_W]),
                .b      (opnd[SLICE_W-1:0]),
                .cin    (cin_k),
                .sum_q  (sum_raw[k]),
                .cout_q (carry_q[k])
            );

            // Exit deskew: lower bytes wait for the top slice to finish.
            bpa_delay #(.W(SLICE_W), .DEPTH(SLICES-1-k)) u_deskew (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (sum_raw[k]),
                .q     (sum_aligned[k])
            );
        end
    endgenerate

    bpa_delay #(.W(1), .DEPTH(LAT)) u_valid (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (in_valid),
        .q     (out_valid)
    );

    assign out_sum  = sum_aligned;
    assign out_cout = carry_q[SLICES-1];
endmodule

// File: rtl/bpa_chk.sv
module bpa_chk #(
    parameter int WIDTH = 32,
    parameter int LAT   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIDTH-1:0] in_a,
    input logic [WIDTH-1:0] in_b,
    input logic             in_cin,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_sum,
    input logic             out_cout
);
    logic           hist_v [LAT];
    logic [WIDTH:0] hist_r [LAT];
    logic [WIDTH:0] ref_now;

    always_comb begin
        ref_now = {1'b0, in_a} + {1'b0, in_b} + {{WIDTH{1'b0}}, in_cin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                hist_v[i] <= 1'b0;
                hist_r[i] <= '0;
            end
        end else begin
            hist_v[0] <= in_valid;
            hist_r[0] <= ref_now;
            for (int i = 1; i < LAT; i++) begin
                hist_v[i] <= hist_v[i-1];
                hist_r[i] <= hist_r[i-1];
            end
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_sum == '0 && !out_cout));

    // R4
    latency_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid == hist_v[LAT-1]);

    // R2
    sum_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_sum == hist_r[LAT-1][WIDTH-1:0]);

    // R3
    cout_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_cout == hist_r[LAT-1][WIDTH]);
endmodule

bind byte_pipe_adder bpa_chk #(.WIDTH(WIDTH), .LAT(SLICES)) u_bpa_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_cin    (in_cin),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .out_cout  (out_cout)
);

// File: tb/tb_byte_pipe_adder.sv
module tb_byte_pipe_adder;
    localparam int NV = 10;
    // Each entry: {a, b, cin}
    localparam logic [64:0] VEC [NV] = '{
        {32'h0000_0001, 32'h0000_0002, 1'b0},
        {32'hFFFF_FFFF, 32'h0000_0000, 1'b1},   // R6 full ripple
        {32'h0000_00FF, 32'h0000_0001, 1'b0},   // R7 byte 0 -> 1
        {32'h0000_FFFF, 32'h0000_0000, 1'b1},   // R7 byte 1 -> 2
        {32'h00FF_FFFF, 32'h0000_0001, 1'b0},   // R7 byte 2 -> 3
        {32'h8000_0000, 32'h8000_0000, 1'b0},   // R3 carry-out only
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1},
        {32'h1234_5678, 32'h9ABC_DEF0, 1'b1},
        {32'hDEAD_BEEF, 32'h2152_4111, 1'b0},
        {32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        in_cin = 1'b0;
    logic        out_valid;
    logic [31:0] out_sum;
    logic        out_cout;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    byte_pipe_adder dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_cin    (in_cin),
        .out_valid (out_valid),
        .out_sum   (out_sum),
        .out_cout  (out_cout)
    );

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [32:0] ref_add(input logic [31:0] a, input logic [31:0] b, input logic c);
        return {1'b0, a} + {1'b0, b} + {32'd0, c};
    endfunction

    task automatic one_shot(input logic [31:0] a, input logic [31:0] b, input logic c, input string tag);
        logic [32:0] exp;
        exp = ref_add(a, b, c);
        @(negedge clk);
        in_valid = 1'b1; in_a = a; in_b = b; in_cin = c;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (k == 1) begin
                in_valid = 1'b0; in_a = '1; in_b = '1; in_cin = 1'b1;
            end
            if (k < 4) check("R4 early valid", {32'd0, out_valid}, 33'd0);
            else begin
                check("R4 valid", {32'd0, out_valid}, 33'd1);
                check({tag, " sum"}, {1'b0, out_sum}, {1'b0, exp[31:0]});
                check({tag, " cout"}, {32'd0, out_cout}, {32'd0, exp[32]});
            end
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [32:0] exp;
        logic        pat [5];
        logic [31:0] pa [5];
        logic [31:0] pb [5];
        logic        pc [5];

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid", {32'd0, out_valid}, 33'd0);
        check("R1 sum", {1'b0, out_sum}, 33'd0);
        check("R1 cout", {32'd0, out_cout}, 33'd0);
        rst_n = 1'b1;

        // R5: back-to-back stream through the table
        for (int j = 0; j < NV + 4; j++) begin
            @(negedge clk);
            if (j >= 4) begin
                exp = ref_add(VEC[j-4][64:33], VEC[j-4][32:1], VEC[j-4][0]);
                check("R5 valid", {32'd0, out_valid}, 33'd1);
                check("R2 sum", {1'b0, out_sum}, {1'b0, exp[31:0]});
                check("R3 cout", {32'd0, out_cout}, {32'd0, exp[32]});
            end else begin
                check("R4 fill valid", {32'd0, out_valid}, 33'd0);
            end
            if (j < NV) begin
                in_valid = 1'b1;
                {in_a, in_b, in_cin} = VEC[j];
            end else begin
                in_valid = 1'b0;
            end
        end

        // Directed single problems: latency and carry corners
        one_shot(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R6");
        one_shot(32'h0000_00FF, 32'h0000_0001, 1'b0, "R7");
        one_shot(32'h00FF_FFFF, 32'h0000_0000, 1'b1, "R7");

        // R8: idle slots with garbage data between valid problems
        pat = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
        pa  = '{32'h0000_FFFF, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h0101_0101, 32'hFFFF_FFFF};
        pb  = '{32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0001, 32'h00FF_00FF, 32'hFFFF_FFFF};
        pc  = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
        for (int j = 0; j < 9; j++) begin
            @(negedge clk);
            if (j >= 4) begin
                check("R8 valid", {32'd0, out_valid}, {32'd0, pat[j-4]});
                if (pat[j-4]) begin
                    exp = ref_add(pa[j-4], pb[j-4], pc[j-4]);
                    check("R8 sum", {1'b0, out_sum}, {1'b0, exp[31:0]});
                    check("R8 cout", {32'd0, out_cout}, {32'd0, exp[32]});
                end
            end
            if (j < 5) begin
                in_valid = pat[j]; in_a = pa[j]; in_b = pb[j]; in_cin = pc[j];
            end else begin
                in_valid = 1'b0;
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule